// File: doc/BRIEF.md
# Masked Interrupt Controller with Halt Wakeup

This block collects interrupt requests from up to 32 peripheral sources for a single CPU. Each request pulse latches a bit in a flag register. Software acknowledges a flag by writing a one to its bit. An enable register selects which flagged sources may interrupt the CPU. A master-enable register gates the interrupt line as a whole. All three registers are reached through a 16-bit register port, and each 32-bit register is split into a low half and a high half.

The controller drives three outputs:
- a level interrupt line to the CPU;
- a one-cycle delivery pulse, which fires once the CPU's own interrupt-disable input is clear;
- a one-cycle wake pulse, which ends a CPU halt.

Wakeup deliberately ignores the master enable. A request that arrives at an enabled source wakes a halted CPU even when interrupts are globally off. Writing the enable or master register re-evaluates the interrupt condition, so an interrupt that is already flagged and enabled is raised at once.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After a synchronous reset, all registers read zero and `irq_o`, `irq_take_o` and `wake_o` are low.
- R2: Register map on `reg_addr`: 0 is the master enable, 1 is the enable low half, 2 is the enable high half, 3 is the flag low half and 4 is the flag high half. `reg_rdata` returns the register selected in the previous cycle.
- R3: A pulse on `src_req[n]` sets flag bit n whatever its enable bit. Sources 0–15 appear as bits 0–15 of the flag low half. Sources 16–31 appear as bits 0–15 of the flag high half.
- R4: Writing a one to a flag bit clears it. Writing a zero to a flag bit leaves it unchanged.
- R5: If a request and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R6: `irq_o` is high exactly when the master register is nonzero and (enable AND flag) is nonzero. It reflects the register state after the same clock edge.
- R7: A write to the enable or master register that makes the condition true raises `irq_o` after that write's clock edge.
- R8: `wake_o` pulses for one cycle, the cycle after a request arrives at a source whose enable bit is set. This happens even when the master register is zero.
- R9: When the condition is true, a request to an enabled source or a write to the enable or master register sets a pending latch. While `cpu_irq_dis` is high, `irq_take_o` stays low. Once `cpu_irq_dis` is low, `irq_take_o` pulses for one cycle and the latch clears.
- R10: The enable and master registers read back all 16 written bits. Any nonzero master value enables the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 32 | Per-source request pulses |
| reg_addr | input | 3 | Register select for both write and read |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| cpu_irq_dis | input | 1 | CPU interrupt-disable flag |
| irq_o | output | 1 | Level interrupt line |
| irq_take_o | output | 1 | One-cycle delivery pulse |
| wake_o | output | 1 | One-cycle halt wakeup pulse |

## Verification
The assertions assume that `src_req` and `cpu_irq_dis` are low while reset is held. They also assume that a write never changes the enable register in the same cycle as a request that depends on it. The wake check uses the enable value from before the edge.

The stimulus follows these rules. Requests are driven low throughout reset. Inputs change only on the falling edge. Every register write finishes before the request pulses that test it. The one exception is the deliberate collision between a request and a flag-clearing write, and it involves no enable change.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  localparam int unsigned MASTER_ADDR = 0;

  function automatic int unsigned en_addr(input int unsigned half);
    return 1 + half;
  endfunction

  function automatic int unsigned flag_addr(input int unsigned half, input int unsigned num_half);
    return 1 + num_half + half;
  endfunction
endpackage

// File: rtl/iwc_enable_bank.sv
module iwc_enable_bank
  import iwc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned AW      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [AW-1:0]      addr,
  input  logic [HALF_W-1:0]  wdata,
  output logic [HALF_W-1:0]  master_q,
  output logic [HALF_W-1:0]  master_d,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_d,
  output logic               cfg_wr
);
  localparam int unsigned NUM_HALF = NUM_SRC / HALF_W;

  logic [NUM_HALF-1:0] half_hit;
  logic                master_hit;

  assign master_hit = wr && (addr == AW'(MASTER_ADDR));
  assign master_d   = master_hit ? wdata : master_q;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign half_hit[h] = wr && (addr == AW'(en_addr(h)));
    assign en_d[h*HALF_W +: HALF_W] = half_hit[h] ? wdata : en_q[h*HALF_W +: HALF_W];
  end

  assign cfg_wr = master_hit || (|half_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= '0;
      en_q     <= '0;
    end else begin
      master_q <= master_d;
      en_q     <= en_d;
    end
  end

  // R10: a master write stores the written data.
  a_r10_master_store: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && master_hit) |-> master_q == $past(wdata));
endmodule

// File: rtl/iwc_flag_bank.sv
module iwc_flag_bank
  import iwc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned AW      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic               wr,
  input  logic [AW-1:0]      addr,
  input  logic [HALF_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] flag_q,
  output logic [NUM_SRC-1:0] flag_d
);
  localparam int unsigned NUM_HALF = NUM_SRC / HALF_W;

  logic [NUM_SRC-1:0] clr_mask;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic hit;
    assign hit = wr && (addr == AW'(flag_addr(h, NUM_HALF)));
    assign clr_mask[h*HALF_W +: HALF_W] = hit ? wdata : '0;
  end

  // A new request takes precedence over a clear of the same bit.
  assign flag_d = req | (flag_q & ~clr_mask);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_d;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R5: a request always leaves its flag set.
    a_r5_req_wins: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && req[i]) |-> flag_q[i]);
    // R4: a flag drops only after a one was written to its bit.
    a_r4_w1c_only: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $fell(flag_q[i])) |-> $past(clr_mask[i]));
  end
endmodule

// File: rtl/iwc_eval.sv
module iwc_eval #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned HALF_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HALF_W-1:0]  master_d,
  input  logic [NUM_SRC-1:0] en_d,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] flag_d,
  input  logic [NUM_SRC-1:0] req,
  input  logic               cfg_wr,
  input  logic               cpu_irq_dis,
  output logic               irq_o,
  output logic               irq_take_o,
  output logic               wake_o
);
  logic cond_d;
  logic event_d;
  logic pend_q;
  logic pend_d;

  assign cond_d  = (|master_d) && (|(en_d & flag_d));
  assign event_d = cfg_wr || (|(req & en_d));

  always_comb begin
    pend_d = pend_q;
    if (pend_q && !cpu_irq_dis) pend_d = 1'b0;
    if (event_d && cond_d)      pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      irq_o      <= 1'b0;
      irq_take_o <= 1'b0;
      wake_o     <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      irq_o      <= cond_d;
      irq_take_o <= pend_q && !cpu_irq_dis;
      wake_o     <= |(req & en_q);
    end
  end

  // R8: a wake pulse follows a request to an enabled source.
  a_r8_wake_cause: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(|(req & en_q)));
  // R9: delivery happens only while the CPU accepts interrupts.
  a_r9_take_gated: assert property (@(posedge clk) disable iff (rst)
    irq_take_o |-> $past(!cpu_irq_dis));
  // R9: a blocked pending latch is held.
  a_r9_pend_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(pend_q && cpu_irq_dis)) |-> pend_q);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import iwc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned NUM_HALF_P = NUM_SRC / HALF_W,
  parameter int unsigned AW      = $clog2(1 + 2 * NUM_HALF_P)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [AW-1:0]      reg_addr,
  input  logic               reg_wr,
  input  logic [HALF_W-1:0]  reg_wdata,
  output logic [HALF_W-1:0]  reg_rdata,
  input  logic               cpu_irq_dis,
  output logic               irq_o,
  output logic               irq_take_o,
  output logic               wake_o
);
  localparam int unsigned NUM_HALF = NUM_SRC / HALF_W;

  logic [HALF_W-1:0]  master_q, master_d;
  logic [NUM_SRC-1:0] en_q, en_d, flag_q, flag_d;
  logic               cfg_wr;
  logic [HALF_W-1:0]  rd_mux;

  iwc_enable_bank #(.NUM_SRC(NUM_SRC), .HALF_W(HALF_W), .AW(AW)) u_enable (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .master_q(master_q), .master_d(master_d), .en_q(en_q), .en_d(en_d),
    .cfg_wr(cfg_wr)
  );

  iwc_flag_bank #(.NUM_SRC(NUM_SRC), .HALF_W(HALF_W), .AW(AW)) u_flags (
    .clk(clk), .rst(rst), .req(src_req), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .flag_q(flag_q), .flag_d(flag_d)
  );

  iwc_eval #(.NUM_SRC(NUM_SRC), .HALF_W(HALF_W)) u_eval (
    .clk(clk), .rst(rst), .master_d(master_d), .en_d(en_d), .en_q(en_q),
    .flag_d(flag_d), .req(src_req), .cfg_wr(cfg_wr), .cpu_irq_dis(cpu_irq_dis),
    .irq_o(irq_o), .irq_take_o(irq_take_o), .wake_o(wake_o)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(MASTER_ADDR)) rd_mux = master_q;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (reg_addr == AW'(en_addr(h)))             rd_mux = en_q[h*HALF_W +: HALF_W];
      if (reg_addr == AW'(flag_addr(h, NUM_HALF))) rd_mux = flag_q[h*HALF_W +: HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R6: the interrupt line matches the stored register state.
  a_r6_irq_level: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> irq_o == ((|master_q) && (|(en_q & flag_q))));
  // R1: outputs are low right after a reset cycle.
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !irq_take_o && !wake_o && flag_q == '0));
endmodule

// File: tb/irq_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_wake_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_req = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cpu_irq_dis = 1'b1;
  logic        irq_o, irq_take_o, wake_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_wake_ctrl dut_i (
    .clk(clk), .rst(rst), .src_req(src_req), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq_dis(cpu_irq_dis), .irq_o(irq_o), .irq_take_o(irq_take_o),
    .wake_o(wake_o)
  );

  // Vector fields: {master, enable[31:0], request[31:0], exp_irq, exp_wake}
  localparam int NV = 6;
  localparam logic [66:0] VEC [NV] = '{
    {1'b1, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1},
    {1'b0, 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b1},
    {1'b1, 32'h0000_00F0, 32'h0000_0001, 1'b0, 1'b0},
    {1'b1, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1},
    {1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0},
    {1'b1, 32'h0000_FF00, 32'h0001_0100, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] r);
    @(negedge clk);
    src_req = r;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cpu_irq_dis = 1'b1; src_req = '0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    do_reset();
    // R1: reset state, read through the R2 map
    check("R1 irq", irq_o, 0);
    check("R1 take", irq_take_o, 0);
    check("R1 wake", wake_o, 0);
    for (int a = 0; a < 5; a++) begin
      rd16(3'(a), d);
      check("R1 reg", d, 0);
    end

    // Table walk: R3, R6, R8
    for (int v = 0; v < NV; v++) begin
      logic [31:0] en, rq;
      en = VEC[v][65:34];
      rq = VEC[v][33:2];
      wr16(3'd0, {15'd0, VEC[v][66]});
      wr16(3'd1, en[15:0]);
      wr16(3'd2, en[31:16]);
      wr16(3'd3, 16'hFFFF);
      wr16(3'd4, 16'hFFFF);
      pulse(rq);
      check("R8 wake", wake_o, VEC[v][0]);
      check("R6 irq", irq_o, VEC[v][1]);
      rd16(3'd3, d);
      check("R3 flag low half", d, rq[15:0]);
      rd16(3'd4, d);
      check("R3 flag high half", d, rq[31:16]);
    end

    // R4: write-one-to-clear, zeros ignored
    do_reset();
    pulse(32'h0000_0005);
    wr16(3'd3, 16'h0004);
    rd16(3'd3, d);
    check("R4 w1c", d, 16'h0001);
    wr16(3'd3, 16'h0000);
    rd16(3'd3, d);
    check("R4 zero write", d, 16'h0001);

    // R5: request and clear collide on bit 0
    @(negedge clk);
    reg_addr = 3'd3; reg_wdata = 16'h0001; reg_wr = 1'b1; src_req = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0; src_req = '0;
    rd16(3'd3, d);
    check("R5 request wins", d, 16'h0001);

    // R7: enable write raises the line for an already pending flag
    do_reset();
    wr16(3'd0, 16'h0001);
    pulse(32'h0000_0008);
    check("R7 before enable", irq_o, 0);
    wr16(3'd1, 16'h0008);
    check("R7 after enable write", irq_o, 1);
    wr16(3'd0, 16'h0000);
    check("R6 master off", irq_o, 0);
    check("R8 wake idle", wake_o, 0);
    wr16(3'd0, 16'h0100);
    check("R7 after master write", irq_o, 1);
    rd16(3'd0, d);
    check("R10 master readback", d, 16'h0100);
    rd16(3'd1, d);
    check("R10 enable readback", d, 16'h0008);
    wr16(3'd3, 16'h0008);
    check("R6 cleared flag drops irq", irq_o, 0);

    // R9: delivery held while disabled, then one pulse
    do_reset();
    wr16(3'd0, 16'h0001);
    wr16(3'd2, 16'h0002);
    pulse(32'h0002_0000);
    check("R6 high-half source", irq_o, 1);
    repeat (3) @(negedge clk);
    check("R9 held while disabled", irq_take_o, 0);
    cpu_irq_dis = 1'b0;
    @(negedge clk);
    check("R9 take pulse", irq_take_o, 1);
    @(negedge clk);
    check("R9 single pulse", irq_take_o, 0);
    check("R9 line unaffected", irq_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule